// File: doc/BRIEF.md
# XOR-Coded Multi-Write-Port RAM

This block is a small RAM with three read/write ports and one extra read-only port. All three write ports can store data in the same clock cycle. It does not need a storage array with more than one writer. Instead, each write port owns a storage bank, and only that port writes it. Each bank can be read combinationally at the address of every port.

Data is held in coded form. When a port writes, its bank location takes the new data XORed with the contents of every other bank at that address. A read XORs all banks at the requested address. The terms from the other banks then cancel, and the result is the value most recently written to that address, whichever port wrote it.

Read data is registered, so each read port behaves as a read-before-write synchronous RAM port. The data width, depth and port counts are parameters. The defaults are 8-bit words, 16 locations, three writers and one read-only port.

Top module: `xmw_ram`

## Requirements
- R1: A read on any of the three read/write ports returns the value most recently written to that address, whichever of the three ports wrote it.
- R2: The read-only port returns the same value as R1 for its own address.
- R3: Read data is registered. The address present at a rising edge selects the data shown on the read output from that edge until the next edge.
- R4: A read at an address that is being written in the same cycle, by its own port or by another port, returns the contents from before that write. The new value appears from the following read on.
- R5: Every address reads as zero until it is first written.
- R6: The reset is synchronous and active high. It sets every read output to zero on the next rising edge and leaves the stored contents unchanged, so the data reads back after reset is released.
- R7: Writes from all three ports in one cycle, at distinct addresses, all take effect. Two ports writing the same address in one cycle is not allowed; the result is undefined and the checker flags it.
- R8: A write changes only its own address. The lowest address (0) and the highest address (15) keep their values while other locations are written.
- R9: When a second port overwrites an address that another port wrote earlier, later reads return the second port's data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all writes and read registers update on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the read outputs |
| wr_en | input | NWR (3) | Write enable; bit k belongs to read/write port k |
| rw_addr | input | NWR x AW (3x4) | Address of each read/write port, used for both its read and its write |
| wr_data | input | NWR x DW (3x8) | Write data of each read/write port |
| ro_addr | input | NRO x AW (1x4) | Address of the read-only port |
| rw_rdata | output | NWR x DW (3x8) | Registered read data of each read/write port |
| ro_rdata | output | NRO x DW (1x8) | Registered read data of the read-only port |

## Verification
The hardest case to reach is a read that depends on cancellation across several banks. This happens when one address has been written by one port and then overwritten by another. It also happens when all three ports write in the same cycle while other ports read the locations being written. The table of vectors places these sequences directly: an overwrite chain on one address by port 0, then port 1, then port 2; a cycle in which all three ports write at once; and a swap of which port owns which address. A long random phase then keeps the three write addresses distinct in every cycle and compares all four outputs with a plain single-array model. A mid-run reset shows that the outputs clear to zero while the stored values survive.

// File: rtl/xmw_pkg.sv
package xmw_pkg;
  // Default sizes shared by the RAM, its checker and the bench
  localparam int unsigned XMW_DW_DEFAULT    = 8;
  localparam int unsigned XMW_DEPTH_DEFAULT = 16;
  localparam int unsigned XMW_NWR_DEFAULT   = 3;
  localparam int unsigned XMW_NRO_DEFAULT   = 1;
endpackage

// File: rtl/xmw_bank.sv
// One storage bank: a single write port, NTAP combinational read taps.
module xmw_bank #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned NTAP  = 4,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      we,
  input  logic [AW-1:0]             waddr,
  input  logic [DW-1:0]             wdata,
  input  logic [NTAP-1:0][AW-1:0]   taddr,
  output logic [NTAP-1:0][DW-1:0]   tdata
);

  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < int'(DEPTH); i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar t = 0; t < int'(NTAP); t++) begin : g_tap
    assign tdata[t] = mem[taddr[t]];
  end

endmodule

// File: rtl/xmw_xor_fold.sv
// XOR of N words.
module xmw_xor_fold #(
  parameter int unsigned DW = 8,
  parameter int unsigned N  = 3
) (
  input  logic [N-1:0][DW-1:0] terms,
  output logic [DW-1:0]        folded
);

  always_comb begin
    folded = '0;
    for (int i = 0; i < int'(N); i++) folded = folded ^ terms[i];
  end

endmodule

// File: rtl/xmw_rdreg.sv
// Output register stage for all read ports, synchronous active-high reset.
module xmw_rdreg #(
  parameter int unsigned DW = 8,
  parameter int unsigned NP = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NP-1:0][DW-1:0] d,
  output logic [NP-1:0][DW-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end

endmodule

// File: rtl/xmw_ram.sv
// Multi-write-port RAM built from single-writer banks with XOR coding.
module xmw_ram
  import xmw_pkg::*;
#(
  parameter int unsigned DW    = XMW_DW_DEFAULT,
  parameter int unsigned DEPTH = XMW_DEPTH_DEFAULT,
  parameter int unsigned NWR   = XMW_NWR_DEFAULT,
  parameter int unsigned NRO   = XMW_NRO_DEFAULT,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NWR-1:0]         wr_en,
  input  logic [NWR-1:0][AW-1:0] rw_addr,
  input  logic [NWR-1:0][DW-1:0] wr_data,
  input  logic [NRO-1:0][AW-1:0] ro_addr,
  output logic [NWR-1:0][DW-1:0] rw_rdata,
  output logic [NRO-1:0][DW-1:0] ro_rdata
);

  localparam int unsigned NP = NWR + NRO;

  // Port p < NWR is a read/write port, the rest are read-only
  logic [NP-1:0][AW-1:0]           tap_addr;
  logic [NWR-1:0][NP-1:0][DW-1:0]  bank_rd;   // [bank][port]
  logic [NP-1:0][NWR-1:0][DW-1:0]  by_port;   // [port][bank]
  logic [NP-1:0][DW-1:0]           port_xor;  // decoded value per port
  logic [NWR-1:0][DW-1:0]          enc;       // coded write word per bank
  logic [NP-1:0][DW-1:0]           rd_all;

  assign tap_addr = {ro_addr, rw_addr};

  for (genvar b = 0; b < int'(NWR); b++) begin : g_bank
    xmw_bank #(.DW(DW), .DEPTH(DEPTH), .NTAP(NP)) u_bank (
      .clk   (clk),
      .we    (wr_en[b]),
      .waddr (rw_addr[b]),
      .wdata (enc[b]),
      .taddr (tap_addr),
      .tdata (bank_rd[b])
    );
    for (genvar p = 0; p < int'(NP); p++) begin : g_xpose
      assign by_port[p][b] = bank_rd[b][p];
    end
  end

  for (genvar p = 0; p < int'(NP); p++) begin : g_dec
    xmw_xor_fold #(.DW(DW), .N(NWR)) u_fold (
      .terms  (by_port[p]),
      .folded (port_xor[p])
    );
  end

  // Removing the writer's own bank term from the full XOR leaves the
  // XOR of every other bank at that address.
  for (genvar k = 0; k < int'(NWR); k++) begin : g_enc
    assign enc[k] = wr_data[k] ^ port_xor[k] ^ bank_rd[k][k];
  end

  xmw_rdreg #(.DW(DW), .NP(NP)) u_rdreg (
    .clk (clk),
    .rst (rst),
    .d   (port_xor),
    .q   (rd_all)
  );

  assign rw_rdata = rd_all[NWR-1:0];
  assign ro_rdata = rd_all[NP-1:NWR];

endmodule

// File: rtl/xmw_ram_chk.sv
// Assertion checker attached to xmw_ram. Holds a plain single-array
// shadow of the memory and compares every registered read with it.
module xmw_ram_chk
  import xmw_pkg::*;
#(
  parameter int unsigned DW    = XMW_DW_DEFAULT,
  parameter int unsigned DEPTH = XMW_DEPTH_DEFAULT,
  parameter int unsigned NWR   = XMW_NWR_DEFAULT,
  parameter int unsigned NRO   = XMW_NRO_DEFAULT,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input logic                   clk,
  input logic                   rst,
  input logic [NWR-1:0]         wr_en,
  input logic [NWR-1:0][AW-1:0] rw_addr,
  input logic [NWR-1:0][DW-1:0] wr_data,
  input logic [NRO-1:0][AW-1:0] ro_addr,
  input logic [NWR-1:0][DW-1:0] rw_rdata,
  input logic [NRO-1:0][DW-1:0] ro_rdata
);

  localparam int unsigned NP = NWR + NRO;

  logic [DW-1:0]         shadow [DEPTH];
  logic [NP-1:0][AW-1:0] all_addr;
  logic [NP-1:0][DW-1:0] exp_q;
  logic                  clash;

  assign all_addr = {ro_addr, rw_addr};

  initial begin
    for (int i = 0; i < int'(DEPTH); i++) shadow[i] = '0;
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < int'(NWR); k++) begin
      if (wr_en[k]) shadow[rw_addr[k]] <= wr_data[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) exp_q <= '0;
    else begin
      for (int p = 0; p < int'(NP); p++) exp_q[p] <= shadow[all_addr[p]];
    end
  end

  always_comb begin
    clash = 1'b0;
    for (int i = 0; i < int'(NWR); i++) begin
      for (int j = i + 1; j < int'(NWR); j++) begin
        if (wr_en[i] && wr_en[j] && rw_addr[i] == rw_addr[j]) clash = 1'b1;
      end
    end
  end

  // R7: two ports must not write one address in the same cycle
  p_no_addr_clash_r7: assert property (@(posedge clk) disable iff (rst) !clash);

  // R6: reset clears every read output on the next edge
  p_reset_clears_r6: assert property (@(posedge clk)
    rst |=> (rw_rdata == '0 && ro_rdata == '0));

  // R1 (with R3, R4, R5): each read/write port matches the shadow array
  for (genvar p = 0; p < int'(NWR); p++) begin : g_rw
    p_rw_coherent_r1: assert property (@(posedge clk) disable iff (rst)
      rw_rdata[p] == exp_q[p]);
  end

  // R2: each read-only port matches the shadow array
  for (genvar r = 0; r < int'(NRO); r++) begin : g_ro
    p_ro_coherent_r2: assert property (@(posedge clk) disable iff (rst)
      ro_rdata[r] == exp_q[NWR + r]);
  end

endmodule

bind xmw_ram xmw_ram_chk #(.DW(DW), .DEPTH(DEPTH), .NWR(NWR), .NRO(NRO)) u_chk (.*);

// File: tb/xmw_ram_test.sv
module xmw_ram_test;

  typedef struct packed {
    logic [2:0]      we;   // bit k = port k
    logic [3:0][3:0] a;    // {ro, p2, p1, p0}
    logic [2:0][7:0] d;    // {p2, p1, p0}
    logic [3:0][7:0] e;    // expected {ro, p2, p1, p0}
  } vec_t;

  localparam int NV = 11;
  localparam vec_t TBL [NV] = '{
    // R4 R5 R7: all ports write, reads see zero (old contents)
    '{we:3'b111, a:{4'd1,4'd3,4'd2,4'd1},  d:{8'hC3,8'hB2,8'hA1}, e:{8'h00,8'h00,8'h00,8'h00}},
    // R1 R2 R7: data from each writer seen on other ports
    '{we:3'b000, a:{4'd3,4'd1,4'd3,4'd2},  d:'0,                  e:{8'hC3,8'hA1,8'hC3,8'hB2}},
    // R4 R9: port 1 overwrites port 0's address, same-cycle reads old
    '{we:3'b010, a:{4'd1,4'd4,4'd1,4'd1},  d:{8'h00,8'h5D,8'h00}, e:{8'hA1,8'h00,8'hA1,8'hA1}},
    // R9: port 2 overwrites again
    '{we:3'b100, a:{4'd1,4'd1,4'd2,4'd1},  d:{8'h77,8'h00,8'h00}, e:{8'h5D,8'h5D,8'hB2,8'h5D}},
    // R9: last writer wins on all ports
    '{we:3'b000, a:{4'd1,4'd1,4'd1,4'd1},  d:'0,                  e:{8'h77,8'h77,8'h77,8'h77}},
    // R5 R8: write top address, address 0 untouched
    '{we:3'b001, a:{4'd15,4'd14,4'd0,4'd15}, d:{8'h00,8'h00,8'hFF}, e:{8'h00,8'h00,8'h00,8'h00}},
    '{we:3'b000, a:{4'd15,4'd0,4'd15,4'd15}, d:'0,                e:{8'hFF,8'h00,8'hFF,8'hFF}},
    // R4 R7: three writes, other addresses read old values
    '{we:3'b111, a:{4'd1,4'd15,4'd3,4'd2}, d:{8'h33,8'h22,8'h11}, e:{8'h77,8'hFF,8'hC3,8'hB2}},
    '{we:3'b000, a:{4'd2,4'd15,4'd3,4'd2}, d:'0,                  e:{8'h11,8'h33,8'h22,8'h11}},
    // R9: ownership swap between ports 0 and 1
    '{we:3'b011, a:{4'd0,4'd1,4'd2,4'd3},  d:{8'h00,8'h55,8'h44}, e:{8'h00,8'h77,8'h11,8'h22}},
    '{we:3'b000, a:{4'd3,4'd1,4'd2,4'd3},  d:'0,                  e:{8'h44,8'h77,8'h55,8'h44}}
  };

  logic            clk = 1'b0;
  logic            rst;
  logic [2:0]      wr_en;
  logic [2:0][3:0] rw_addr;
  logic [2:0][7:0] wr_data;
  logic [0:0][3:0] ro_addr;
  logic [2:0][7:0] rw_rdata;
  logic [0:0][7:0] ro_rdata;

  logic [7:0] ref_mem [16];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  xmw_ram uut (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .rw_addr  (rw_addr),
    .wr_data  (wr_data),
    .ro_addr  (ro_addr),
    .rw_rdata (rw_rdata),
    .ro_rdata (ro_rdata)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag, input logic [3:0][7:0] expv);
    chk({tag, " port0"}, rw_rdata[0], expv[0]);
    chk({tag, " port1"}, rw_rdata[1], expv[1]);
    chk({tag, " port2"}, rw_rdata[2], expv[2]);
    chk({tag, " ro"},    ro_rdata[0], expv[3]);
  endtask

  // Called at a falling edge; returns at the next falling edge with outputs valid
  task automatic run_cycle(input logic [2:0] we, input logic [3:0][3:0] a,
                           input logic [2:0][7:0] d, input string tag,
                           input bit use_tbl, input logic [3:0][7:0] etab);
    logic [3:0][7:0] expv;
    for (int p = 0; p < 4; p++) expv[p] = ref_mem[a[p]];
    if (use_tbl) expv = etab;
    wr_en = we;
    rw_addr = a[2:0];
    ro_addr[0] = a[3];
    wr_data = d;
    for (int k = 0; k < 3; k++) if (we[k]) ref_mem[a[k]] = d[k];
    @(posedge clk);
    @(negedge clk);
    chk_all(tag, expv);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    string row_tag [NV];
    logic [3:0][3:0] a;
    logic [2:0][7:0] d;
    row_tag[0] = "R4 R5 R7 row0";  row_tag[1] = "R1 R2 R7 row1";
    row_tag[2] = "R4 R9 row2";     row_tag[3] = "R9 row3";
    row_tag[4] = "R9 R3 row4";     row_tag[5] = "R5 R8 row5";
    row_tag[6] = "R8 row6";        row_tag[7] = "R4 R7 row7";
    row_tag[8] = "R7 R1 row8";     row_tag[9] = "R9 R4 row9";
    row_tag[10] = "R9 R2 row10";

    for (int i = 0; i < 16; i++) ref_mem[i] = '0;
    rst = 1'b1; wr_en = '0; rw_addr = '0; ro_addr = '0; wr_data = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk_all("R6 reset state", '0);
    rst = 1'b0;

    // Vector table
    for (int i = 0; i < NV; i++) begin
      run_cycle(TBL[i].we, TBL[i].a, TBL[i].d, row_tag[i], 1'b1, TBL[i].e);
    end

    // Random traffic, distinct write addresses each cycle
    for (int n = 0; n < 400; n++) begin
      a[0] = 4'($urandom);
      a[1] = a[0] ^ 4'(1 + ($urandom % 15));
      do a[2] = 4'($urandom); while (a[2] == a[0] || a[2] == a[1]);
      a[3] = 4'($urandom);
      d = {8'($urandom), 8'($urandom), 8'($urandom)};
      run_cycle(3'($urandom), a, d, "R1 R2 R4 random", 1'b0, '0);
    end

    // R6: reset mid-run clears outputs but keeps contents
    run_cycle(3'b001, {4'd6,4'd9,4'd8,4'd6}, {8'h00,8'h00,8'h6A}, "R4 pre-reset", 1'b0, '0);
    rst = 1'b1; wr_en = '0;
    rw_addr = {4'd6, 4'd6, 4'd6}; ro_addr[0] = 4'd6;
    @(posedge clk);
    @(negedge clk);
    chk_all("R6 outputs in reset", '0);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk_all("R6 contents kept", {8'h6A, 8'h6A, 8'h6A, 8'h6A});

    // R3: output holds for a full cycle when address and contents are unchanged
    run_cycle(3'b000, {4'd6,4'd6,4'd6,4'd6}, '0, "R3 hold", 1'b0, '0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule